// File: doc/BRIEF.md
# Branch and Load Interlock for an Eight-Stage Pipeline

This controller sits beside the decode stage of an in-order integer pipeline with eight stages: two fetch stages (IF, IS), register fetch (RF), execute (EX), two data-cache stages (DF, DS), tag check (TC) and write-back (WB). Each cycle it looks at the instruction held in RF and at the branch that has reached EX. From these it decides whether the front three stages must freeze, whether EX receives a bubble, whether the instruction after a branch is annulled, and whether fetch must restart at a branch target. Load data becomes usable two cycles after the load leaves EX, and a branch resolves in EX. So a consumer directly behind a load waits two cycles, and a taken branch costs its delay slot plus two bubbles.

The controller keeps a short record of the loads that are in flight, one entry for each stage between EX and the point where load data can be forwarded. It also keeps a record of the branch in EX, a one-cycle "delay slot still waiting" flag, and a down-counter that places the post-branch bubbles. A branch of the "likely" kind that is not taken annuls its delay slot. The annulled instruction never stalls and leaves no load record behind. A branch sitting in the delay slot of another branch is outside the contract.

Top module: `pipe_interlock`

## Requirements
- R1: After reset, with no valid instruction in RF, `stall_o`, `ex_bubble_o`, `squash_o` and `redirect_o` are all low.
- R2: Whenever `stall_o` is high, `ex_bubble_o` is also high. The IF, IS and RF stages hold their contents and EX receives a bubble.
- R3: A valid RF instruction whose source register equals the destination of the load directly ahead of it sees `stall_o` high for exactly two cycles.
- R4: With exactly one instruction between the load and its consumer, the stall lasts one cycle. With two or more instructions between them, there is no stall.
- R5: Register 0 is never a dependency: a load to register 0 is not tracked and a source of 0 never matches. An RF instruction with `rf_valid_i` low never stalls.
- R6: `redirect_o` is high in the cycle when a branch occupies EX and `ex_taken_i` is high. The delay-slot instruction in RF is not squashed.
- R7: After a taken branch, once the delay slot has left RF, `ex_bubble_o` is high for the next two cycles and `stall_o` stays low in them, even if the RF instruction matches a tracked load.
- R8: If the delay slot is itself stalled by a load when the branch resolves, the two post-branch bubbles begin only after the delay slot has advanced into EX.
- R9: A likely-type branch in EX with `ex_taken_i` low raises `squash_o` and `ex_bubble_o` and not `redirect_o`. It overrides any load stall of the delay slot, and a squashed load creates no hazard later.
- R10: A likely-type branch that is taken behaves as an ordinary taken branch: redirect, delay slot kept, two bubbles.
- R11: An ordinary branch that is not taken produces no redirect, no squash and no bubbles. Its delay slot executes, and a load in the delay slot is tracked.
- R12: `ex_taken_i` has no effect unless a branch occupies EX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rf_valid_i | input | 1 | RF holds a real instruction |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rf_src_a_i | input | 5 | First source register of RF instruction (0 = none) |
| rf_src_b_i | input | 5 | Second source register of RF instruction (0 = none) |
| rf_dst_i | input | 5 | Destination register of RF instruction |
| rf_load_i | input | 1 | RF instruction is a load |
| rf_branch_i | input | 1 | RF instruction is a conditional branch |
| rf_likely_i | input | 1 | The branch annuls its delay slot when not taken |
| ex_taken_i | input | 1 | Outcome of the branch in EX, 1 = taken |
| stall_o | output | 1 | Hold IF, IS and RF this cycle |
| ex_bubble_o | output | 1 | Insert a bubble into EX instead of the RF instruction |
| squash_o | output | 1 | Annul the delay-slot instruction in RF |
| redirect_o | output | 1 | Restart fetch at the branch target; discard IF and IS |

## Verification
The hardest case to reach is a taken branch whose delay slot is itself waiting on a load. To build it, a load is issued, then an independent branch, and then a delay slot that reads the load's destination. The branch then resolves in the same cycle in which the slot stalls, so the bubble counter must wait one cycle before it arms. A second hard case is a likely-type branch that falls through while its delay slot both depends on a load and is a load itself. The instruction after it reads that annulled destination, which shows at the ports that the squashed load left no record behind. Wrong-path instructions after taken branches also read live load destinations, to show that post-branch bubbles suppress stalls.

// File: rtl/pipe_interlock_pkg.sv
package pipe_interlock_pkg;
  localparam int unsigned REG_W = 5;

  typedef logic [REG_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     vld;
    reg_idx_t dst;
  } ld_tag_t;
endpackage

// File: rtl/pipe_ld_track.sv
module pipe_ld_track
  import pipe_interlock_pkg::*;
#(
  parameter int unsigned LD_LAT = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  reg_idx_t push_dst_i,
  input  reg_idx_t src_a_i,
  input  reg_idx_t src_b_i,
  output logic     hit_o
);
  // entry 0 = load in EX, entry LD_LAT-1 = last stage before data is forwardable
  ld_tag_t             tag_q [LD_LAT];
  logic [LD_LAT-1:0]   match;

  for (genvar i = 0; i < LD_LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tag_q[0] <= '0;
        else         tag_q[0] <= '{vld: push_i, dst: push_dst_i};
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tag_q[i] <= '0;
        else         tag_q[i] <= tag_q[i-1];
      end
    end

    assign match[i] = tag_q[i].vld &&
                      (((src_a_i != '0) && (src_a_i == tag_q[i].dst)) ||
                       ((src_b_i != '0) && (src_b_i == tag_q[i].dst)));
  end

  assign hit_o = |match;
endmodule

// File: rtl/pipe_br_ctl.sv
module pipe_br_ctl #(
  parameter int unsigned BR_STALLS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_br_i,
  input  logic adv_likely_i,
  input  logic ex_taken_i,
  input  logic stall_i,
  output logic redirect_o,
  output logic squash_o,
  output logic shadow_o
);
  localparam int unsigned CNT_W = $clog2(BR_STALLS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BR_STALLS);

  logic             ex_br_q, ex_likely_q, slot_wait_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pending, arm;

  assign redirect_o = ex_br_q && ex_taken_i;
  assign squash_o   = ex_br_q && ex_likely_q && !ex_taken_i;
  assign shadow_o   = (cnt_q != '0);

  // bubbles start only once the delay slot has left RF
  assign pending = redirect_o || slot_wait_q;
  assign arm     = pending && !stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_br_q     <= 1'b0;
      ex_likely_q <= 1'b0;
      slot_wait_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      ex_br_q     <= adv_br_i;
      ex_likely_q <= adv_likely_i;
      slot_wait_q <= pending && stall_i;
      if (arm)           cnt_q <= CNT_LOAD;
      else if (shadow_o) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_interlock_pkg::*;
#(
  parameter int unsigned LD_LAT    = 2,
  parameter int unsigned BR_STALLS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rf_valid_i,
  input  logic [REG_W-1:0]     rf_src_a_i,
  input  logic [REG_W-1:0]     rf_src_b_i,
  input  logic [REG_W-1:0]     rf_dst_i,
  input  logic                 rf_load_i,
  input  logic                 rf_branch_i,
  input  logic                 rf_likely_i,
  input  logic                 ex_taken_i,
  output logic                 stall_o,
  output logic                 ex_bubble_o,
  output logic                 squash_o,
  output logic                 redirect_o
);
  logic ld_hit, br_shadow, advance, push_ld;

  pipe_ld_track #(.LD_LAT(LD_LAT)) u_ld (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_ld),
    .push_dst_i (rf_dst_i),
    .src_a_i    (rf_src_a_i),
    .src_b_i    (rf_src_b_i),
    .hit_o      (ld_hit)
  );

  pipe_br_ctl #(.BR_STALLS(BR_STALLS)) u_br (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_br_i     (advance && rf_branch_i),
    .adv_likely_i (advance && rf_branch_i && rf_likely_i),
    .ex_taken_i   (ex_taken_i),
    .stall_i      (stall_o),
    .redirect_o   (redirect_o),
    .squash_o     (squash_o),
    .shadow_o     (br_shadow)
  );

  // annul and post-branch shadow win over load interlock
  assign stall_o     = rf_valid_i && ld_hit && !squash_o && !br_shadow;
  assign ex_bubble_o = stall_o || squash_o || br_shadow;
  assign advance     = rf_valid_i && !ex_bubble_o;
  assign push_ld     = advance && rf_load_i && (rf_dst_i != '0);
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk
  import pipe_interlock_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           rf_valid_i,
  input logic [REG_W-1:0] rf_src_a_i,
  input logic [REG_W-1:0] rf_src_b_i,
  input logic [REG_W-1:0] rf_dst_i,
  input logic           rf_load_i,
  input logic           stall_o,
  input logic           ex_bubble_o,
  input logic           squash_o,
  input logic           redirect_o,
  input logic           br_shadow
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r2_stall_bubbles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ex_bubble_o);

  a_r5_invalid_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rf_valid_i |-> !stall_o);

  a_r5_zero_src_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_src_a_i == '0 && rf_src_b_i == '0) |-> !stall_o);

  a_r9_squash_overrides: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (ex_bubble_o && !stall_o && !redirect_o));

  a_r7_two_bubbles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !stall_o) |=> (ex_bubble_o && !stall_o) ##1 (ex_bubble_o && !stall_o));

  a_r3_load_use_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(rf_valid_i && rf_load_i && rf_dst_i != '0 && !ex_bubble_o) &&
     rf_valid_i && !squash_o && !br_shadow &&
     (rf_src_a_i == $past(rf_dst_i) || rf_src_b_i == $past(rf_dst_i)))
    |-> stall_o);
endmodule

bind pipe_interlock pipe_interlock_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rf_valid_i  (rf_valid_i),
  .rf_src_a_i  (rf_src_a_i),
  .rf_src_b_i  (rf_src_b_i),
  .rf_dst_i    (rf_dst_i),
  .rf_load_i   (rf_load_i),
  .stall_o     (stall_o),
  .ex_bubble_o (ex_bubble_o),
  .squash_o    (squash_o),
  .redirect_o  (redirect_o),
  .br_shadow   (br_shadow)
);

// File: tb/pipe_interlock_test.sv
module pipe_interlock_test;
  localparam int CLK_P = 10;

  typedef struct {
    logic  st, bb, sq, rd;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rf_valid_i = 1'b0;
  logic [4:0] rf_src_a_i = '0, rf_src_b_i = '0, rf_dst_i = '0;
  logic       rf_load_i = 1'b0, rf_branch_i = 1'b0, rf_likely_i = 1'b0, ex_taken_i = 1'b0;
  logic       stall_o, ex_bubble_o, squash_o, redirect_o;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];
  bit   done = 1'b0;

  pipe_interlock uut (
    .clk_i(clk), .rst_ni(rst_ni), .rf_valid_i(rf_valid_i),
    .rf_src_a_i(rf_src_a_i), .rf_src_b_i(rf_src_b_i), .rf_dst_i(rf_dst_i),
    .rf_load_i(rf_load_i), .rf_branch_i(rf_branch_i), .rf_likely_i(rf_likely_i),
    .ex_taken_i(ex_taken_i), .stall_o(stall_o), .ex_bubble_o(ex_bubble_o),
    .squash_o(squash_o), .redirect_o(redirect_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // driver: one RF slot per cycle plus expected outputs
  task automatic step(input logic v, input logic [4:0] a, input logic [4:0] b,
                      input logic [4:0] d, input logic ld, input logic br,
                      input logic lk, input logic tk, input logic es, input logic eb,
                      input logic esq, input logic erd, input string tag);
    @(negedge clk);
    rf_valid_i = v; rf_src_a_i = a; rf_src_b_i = b; rf_dst_i = d;
    rf_load_i = ld; rf_branch_i = br; rf_likely_i = lk; ex_taken_i = tk;
    exp_q.push_back('{st: es, bb: eb, sq: esq, rd: erd, tag: tag});
  endtask

  task automatic idle(input int n, input logic tk, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, tk, 0, 0, 0, 0, tag);
  endtask

  // monitor: compare a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if ({stall_o, ex_bubble_o, squash_o, redirect_o} !== {e.st, e.bb, e.sq, e.rd}) begin
          errors++;
          $display("FAIL %s: stall/bubble/squash/redirect actual %b%b%b%b expected %b%b%b%b",
                   e.tag, stall_o, ex_bubble_o, squash_o, redirect_o, e.st, e.bb, e.sq, e.rd);
        end
      end
    end
  end

  initial begin
    #(CLK_P*5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(2, 0, "R1 reset state");

    // R3: consumer right behind load -> 2 stalls
    step(1, 1, 2, 5, 1, 0, 0, 0, 0, 0, 0, 0, "R3 load r5");
    step(1, 5, 3, 4, 0, 0, 0, 0, 1, 1, 0, 0, "R3 stall 1 / R2");
    step(1, 5, 3, 4, 0, 0, 0, 0, 1, 1, 0, 0, "R3 stall 2 / R2");
    step(1, 5, 3, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R3 release");
    idle(3, 0, "R3 drain");

    // R4: one between -> 1 stall
    step(1, 1, 2, 6, 1, 0, 0, 0, 0, 0, 0, 0, "R4 load r6");
    step(1, 1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R4 independent");
    step(1, 7, 6, 8, 0, 0, 0, 0, 1, 1, 0, 0, "R4 stall 1");
    step(1, 7, 6, 8, 0, 0, 0, 0, 0, 0, 0, 0, "R4 release");
    idle(3, 0, "R4 drain");

    // R4: two between -> none
    step(1, 1, 2, 10, 1, 0, 0, 0, 0, 0, 0, 0, "R4 load r10");
    step(1, 1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R4 gap 1");
    step(1, 1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R4 gap 2");
    step(1, 10, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R4 far consumer");
    idle(3, 0, "R4 drain");

    // R5: register 0 and invalid RF
    step(1, 1, 2, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 load r0");
    step(1, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R5 src r0");
    step(1, 1, 2, 9, 1, 0, 0, 0, 0, 0, 0, 0, "R5 load r9");
    step(0, 9, 9, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R5 invalid RF");
    idle(3, 1, "R12 taken with no branch");

    // R6/R7: taken branch, delay slot is load r11, wrong path reads r11
    step(1, 1, 2, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R6 branch");
    step(1, 1, 2, 11, 1, 0, 0, 1, 0, 0, 0, 1, "R6 redirect");
    step(1, 11, 0, 3, 0, 0, 0, 0, 0, 1, 0, 0, "R7 bubble 1");
    step(1, 11, 0, 3, 0, 0, 0, 0, 0, 1, 0, 0, "R7 bubble 2");
    step(1, 11, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R7 target");
    idle(3, 0, "R7 drain");

    // R8: delay slot stalled on load when branch resolves
    step(1, 1, 2, 12, 1, 0, 0, 0, 0, 0, 0, 0, "R8 load r12");
    step(1, 1, 2, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R8 branch");
    step(1, 12, 0, 3, 0, 0, 0, 1, 1, 1, 0, 1, "R8 redirect+stall");
    step(1, 12, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R8 slot advances");
    step(1, 1, 2, 3, 0, 0, 0, 0, 0, 1, 0, 0, "R8 bubble 1");
    step(1, 1, 2, 3, 0, 0, 0, 0, 0, 1, 0, 0, "R8 bubble 2");
    step(1, 1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R8 target");
    idle(3, 0, "R8 drain");

    // R9: likely not taken, slot depends on load and is a load
    step(1, 1, 2, 13, 1, 0, 0, 0, 0, 0, 0, 0, "R9 load r13");
    step(1, 1, 2, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R9 likely branch");
    step(1, 13, 0, 14, 1, 0, 0, 0, 0, 1, 1, 0, "R9 squash");
    step(1, 14, 13, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R9 no hazard from annulled");
    idle(3, 0, "R9 drain");

    // R10: likely taken
    step(1, 1, 2, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R10 likely branch");
    step(1, 1, 2, 3, 0, 0, 0, 1, 0, 0, 0, 1, "R10 redirect no squash");
    step(1, 1, 2, 3, 0, 0, 0, 0, 0, 1, 0, 0, "R10 bubble 1");
    step(1, 1, 2, 3, 0, 0, 0, 0, 0, 1, 0, 0, "R10 bubble 2");
    step(1, 1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R10 target");
    idle(3, 0, "R10 drain");

    // R11: ordinary not taken, delay slot load tracked
    step(1, 1, 2, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R11 branch");
    step(1, 1, 2, 15, 1, 0, 0, 0, 0, 0, 0, 0, "R11 fall through");
    step(1, 15, 0, 3, 0, 0, 0, 0, 1, 1, 0, 0, "R11 slot load stall 1");
    step(1, 15, 0, 3, 0, 0, 0, 0, 1, 1, 0, 0, "R11 slot load stall 2");
    step(1, 15, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R11 release");
    idle(3, 0, "R11 drain");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule